// File: doc/BRIEF.md
# Multi-Mode Configurable Word Store

A 256-entry, 16-bit storage array sits behind one input stream and one output stream. Both streams carry 16-bit data and use a valid/ready pair for flow control. A configuration write picks one of four behaviours, and the chosen behaviour stays in force until the next configuration write. The four behaviours are a programmable delay line, a first-in first-out queue, a table lookup, and a command-driven random-access memory. Each behaviour has its own small controller. A mode multiplexer connects the selected controller to the shared array and to the stream ports. The other controllers are held idle.

A separate table-write port loads words straight into the array. The table-write port is normally used before lookup mode is enabled. It has priority over any stream-side write in the same cycle. A configuration write clears the pointers, counters and output registers of every controller. It does not clear the stored words, so contents survive a change of mode.

Top module: `cfg_mem_unit`

## Requirements
- R1: After reset the unit is in delay mode with a delay of 1. `out_valid_o`, `full_o` and `empty_o` are low, and `in_ready_o` is high.
- R2: A pulse on `cfg_we_i` latches `cfg_mode_i` (0 = delay, 1 = FIFO, 2 = lookup, 3 = RAM) and `cfg_delay_m1_i`. The same pulse clears all controller state, so `out_valid_o` is low in the next cycle and a delay line starts empty again. Array contents are kept.
- R3: In delay mode with `cfg_delay_m1_i` = N-1, where N is 1 to 256, the k-th accepted input produces one output. That output equals input k-N, or zero when k < N.
- R4: In FIFO mode, words leave in the order they were accepted. `empty_o` is high when the queue holds no words. `full_o` is high when it holds 256 words.
- R5: In FIFO mode, `in_ready_o` is low while the queue is full, and a word offered then is not stored. `out_valid_o` is low while the queue is empty. The head word is presented as soon as it is stored.
- R6: In lookup mode, bits [7:0] of an accepted input word address the array, and bits [15:8] are ignored. The stored word appears on `out_data_o` with `out_valid_o` high in the cycle after acceptance.
- R7: When `tbl_we_i` is high, `tbl_data_i` is written at `tbl_addr_i` at the clock edge. This write takes priority over any stream write.
- R8: In RAM mode, an accepted word with `in_cmd_i` = 1 supplies a write address in bits [7:0]. The next accepted word is stored at that address whatever its `in_cmd_i`. Neither word produces an output.
- R9: In RAM mode, an accepted word with `in_cmd_i` = 0 reads the address in bits [7:0]. The data is returned in the following cycle.
- R10: In delay, lookup and RAM modes, a pending output holds `out_valid_o` and `out_data_o` steady while `out_ready_i` is low. `in_ready_o` is low while an output is pending and not being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration load and controller clear |
| cfg_mode_i | input | 2 | Mode select: 0 delay, 1 FIFO, 2 lookup, 3 RAM |
| cfg_delay_m1_i | input | 8 | Delay length minus one |
| tbl_we_i | input | 1 | Table-write strobe |
| tbl_addr_i | input | 8 | Table-write address |
| tbl_data_i | input | 16 | Table-write data |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word can be taken |
| in_data_i | input | 16 | Input word |
| in_cmd_i | input | 1 | RAM mode: 1 = write address word, 0 = read |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word taken |
| out_data_o | output | 16 | Output word |
| full_o | output | 1 | FIFO holds 256 words (FIFO mode only) |
| empty_o | output | 1 | FIFO holds no words (FIFO mode only) |

## Verification
In delay, lookup and RAM-read modes, a result is registered at the edge that accepts its input, so it becomes visible one cycle after acceptance. In FIFO mode, a stored word becomes the head at the edge that writes it. The driver records the expected word at the moment it sees `in_ready_o` high with its input valid. Both the driver and the monitor act one time unit after the falling edge, so the values they see are the ones the next rising edge will use. The monitor takes an item from the expected queue only when it sees `out_valid_o` and `out_ready_i` both high. Held outputs, full and empty flags, and refused writes are sampled at the same point between edges, while back-pressure is applied.

// File: rtl/cfg_mem_pkg.sv
package cfg_mem_pkg;
  typedef enum logic [1:0] {
    MODE_DELAY = 2'd0,
    MODE_FIFO  = 2'd1,
    MODE_LUT   = 2'd2,
    MODE_RAM   = 2'd3
  } mem_mode_e;
endpackage

// File: rtl/cfg_mem_store.sv
module cfg_mem_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read returns pre-edge contents
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfg_mem_delay_ctl.sv
module cfg_mem_delay_ctl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] len_m1_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  logic [ADDR_W-1:0] ptr_q;
  logic              filled_q, out_valid_q;
  logic [DATA_W-1:0] out_data_q;
  logic              acc;

  assign in_ready_o  = !out_valid_q || out_ready_i;
  assign acc         = in_valid_i && in_ready_o;
  assign we_o        = acc;
  assign waddr_o     = ptr_q;
  assign wdata_o     = in_data_i;
  assign raddr_o     = ptr_q;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      filled_q    <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (clr_i) begin
      ptr_q       <= '0;
      filled_q    <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (acc) begin
        out_data_q  <= filled_q ? rdata_i : '0;
        out_valid_q <= 1'b1;
        if (ptr_q == len_m1_i) begin
          ptr_q    <= '0;
          filled_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  // R10
  dly_out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_q && !out_ready_i && !clr_i) |=> (out_valid_q && $stable(out_data_q)));
endmodule

// File: rtl/cfg_mem_fifo_ctl.sv
module cfg_mem_fifo_ctl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] CNT_FULL = DEPTH[ADDR_W:0];

  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [ADDR_W:0]   cnt_q;
  logic              push, pop;

  assign full_o      = (cnt_q == CNT_FULL);
  assign empty_o     = (cnt_q == '0);
  assign in_ready_o  = !full_o;
  assign push        = in_valid_i && !full_o;
  assign pop         = !empty_o && out_ready_i;
  assign out_valid_o = !empty_o;
  assign out_data_o  = rdata_i;
  assign we_o        = push;
  assign waddr_o     = wr_ptr_q;
  assign wdata_o     = in_data_i;
  assign raddr_o     = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  fifo_push_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  fifo_pop_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/cfg_mem_lut_ctl.sv
module cfg_mem_lut_ctl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] key_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  logic              out_valid_q, acc;
  logic [DATA_W-1:0] out_data_q;

  assign in_ready_o  = !out_valid_q || out_ready_i;
  assign acc         = in_valid_i && in_ready_o;
  assign raddr_o     = key_i;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (clr_i) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (acc) begin
      out_valid_q <= 1'b1;
      out_data_q  <= rdata_i;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  // R6
  lut_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !clr_i) |=> (out_valid_q && out_data_q == $past(rdata_i)));
endmodule

// File: rtl/cfg_mem_ram_ctl.sv
module cfg_mem_ram_ctl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_cmd_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i
);
  typedef enum logic {ST_IDLE, ST_WDATA} ram_st_e;

  ram_st_e           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              out_valid_q, acc, rd_acc;
  logic [DATA_W-1:0] out_data_q;

  // data phase never produces output, so it never stalls
  assign in_ready_o  = (state_q == ST_WDATA) || !out_valid_q || out_ready_i;
  assign acc         = in_valid_i && in_ready_o;
  assign rd_acc      = acc && (state_q == ST_IDLE) && !in_cmd_i;
  assign we_o        = acc && (state_q == ST_WDATA);
  assign waddr_o     = addr_q;
  assign wdata_o     = in_data_i;
  assign raddr_o     = in_data_i[ADDR_W-1:0];
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (clr_i) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (acc) begin
        if (state_q == ST_WDATA) begin
          state_q <= ST_IDLE;
        end else if (in_cmd_i) begin
          addr_q  <= in_data_i[ADDR_W-1:0];
          state_q <= ST_WDATA;
        end
      end
      if (rd_acc) begin
        out_valid_q <= 1'b1;
        out_data_q  <= rdata_i;
      end else if (out_ready_i) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  // R8
  ram_wr_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && acc && in_cmd_i && !clr_i) |=> (state_q == ST_WDATA && in_ready_o));
  // R9
  ram_rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !clr_i) |=> (out_valid_q && out_data_q == $past(rdata_i)));
endmodule

// File: rtl/cfg_mem_unit.sv
module cfg_mem_unit
  import cfg_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [ADDR_W-1:0] cfg_delay_m1_i,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [DATA_W-1:0] tbl_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_cmd_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              full_o,
  output logic              empty_o
);
  mem_mode_e         mode_q;
  logic [ADDR_W-1:0] len_m1_q;
  logic              sel_dly, sel_fifo, sel_lut, sel_ram;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DELAY;
      len_m1_q <= '0;
    end else if (cfg_we_i) begin
      mode_q   <= mem_mode_e'(cfg_mode_i);
      len_m1_q <= cfg_delay_m1_i;
    end
  end

  assign sel_dly  = (mode_q == MODE_DELAY);
  assign sel_fifo = (mode_q == MODE_FIFO);
  assign sel_lut  = (mode_q == MODE_LUT);
  assign sel_ram  = (mode_q == MODE_RAM);

  logic [DATA_W-1:0] rdata;
  logic              st_we;
  logic [ADDR_W-1:0] st_waddr, st_raddr;
  logic [DATA_W-1:0] st_wdata;

  logic              dly_rdy, dly_ov, dly_we;
  logic [DATA_W-1:0] dly_od, dly_wd;
  logic [ADDR_W-1:0] dly_wa, dly_ra;

  logic              ff_rdy, ff_ov, ff_we, ff_full, ff_empty;
  logic [DATA_W-1:0] ff_od, ff_wd;
  logic [ADDR_W-1:0] ff_wa, ff_ra;

  logic              lut_rdy, lut_ov;
  logic [DATA_W-1:0] lut_od;
  logic [ADDR_W-1:0] lut_ra;

  logic              ram_rdy, ram_ov, ram_we;
  logic [DATA_W-1:0] ram_od, ram_wd;
  logic [ADDR_W-1:0] ram_wa, ram_ra;

  cfg_mem_delay_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dly (
    .clk_i, .rst_ni, .clr_i(cfg_we_i), .len_m1_i(len_m1_q),
    .in_valid_i(in_valid_i && sel_dly), .in_ready_o(dly_rdy), .in_data_i,
    .out_valid_o(dly_ov), .out_ready_i(out_ready_i && sel_dly), .out_data_o(dly_od),
    .we_o(dly_we), .waddr_o(dly_wa), .wdata_o(dly_wd), .raddr_o(dly_ra), .rdata_i(rdata)
  );

  cfg_mem_fifo_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
    .clk_i, .rst_ni, .clr_i(cfg_we_i),
    .in_valid_i(in_valid_i && sel_fifo), .in_ready_o(ff_rdy), .in_data_i,
    .out_valid_o(ff_ov), .out_ready_i(out_ready_i && sel_fifo), .out_data_o(ff_od),
    .full_o(ff_full), .empty_o(ff_empty),
    .we_o(ff_we), .waddr_o(ff_wa), .wdata_o(ff_wd), .raddr_o(ff_ra), .rdata_i(rdata)
  );

  cfg_mem_lut_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lut (
    .clk_i, .rst_ni, .clr_i(cfg_we_i),
    .in_valid_i(in_valid_i && sel_lut), .in_ready_o(lut_rdy), .key_i(in_data_i[ADDR_W-1:0]),
    .out_valid_o(lut_ov), .out_ready_i(out_ready_i && sel_lut), .out_data_o(lut_od),
    .raddr_o(lut_ra), .rdata_i(rdata)
  );

  cfg_mem_ram_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i, .rst_ni, .clr_i(cfg_we_i),
    .in_valid_i(in_valid_i && sel_ram), .in_ready_o(ram_rdy), .in_data_i, .in_cmd_i,
    .out_valid_o(ram_ov), .out_ready_i(out_ready_i && sel_ram), .out_data_o(ram_od),
    .we_o(ram_we), .waddr_o(ram_wa), .wdata_o(ram_wd), .raddr_o(ram_ra), .rdata_i(rdata)
  );

  always_comb begin
    unique case (mode_q)
      MODE_FIFO: begin
        st_we = ff_we;  st_waddr = ff_wa;  st_wdata = ff_wd;  st_raddr = ff_ra;
        in_ready_o = ff_rdy;  out_valid_o = ff_ov;  out_data_o = ff_od;
      end
      MODE_LUT: begin
        st_we = 1'b0;  st_waddr = '0;  st_wdata = '0;  st_raddr = lut_ra;
        in_ready_o = lut_rdy;  out_valid_o = lut_ov;  out_data_o = lut_od;
      end
      MODE_RAM: begin
        st_we = ram_we;  st_waddr = ram_wa;  st_wdata = ram_wd;  st_raddr = ram_ra;
        in_ready_o = ram_rdy;  out_valid_o = ram_ov;  out_data_o = ram_od;
      end
      default: begin
        st_we = dly_we;  st_waddr = dly_wa;  st_wdata = dly_wd;  st_raddr = dly_ra;
        in_ready_o = dly_rdy;  out_valid_o = dly_ov;  out_data_o = dly_od;
      end
    endcase
  end

  assign full_o  = sel_fifo && ff_full;
  assign empty_o = sel_fifo && ff_empty;

  // table-write port wins over stream writes
  cfg_mem_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i,
    .we_i   (tbl_we_i || st_we),
    .waddr_i(tbl_we_i ? tbl_addr_i : st_waddr),
    .wdata_i(tbl_we_i ? tbl_data_i : st_wdata),
    .raddr_i(st_raddr),
    .rdata_o(rdata)
  );

  // R2
  cfg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !out_valid_o);
  // R2
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dly_we, ff_we, ram_we}));
endmodule

// File: tb/cfg_mem_unit_tb.sv
module cfg_mem_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [7:0]  cfg_dm1 = '0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [15:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_cmd = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        full, empty;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_mem_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_delay_m1_i(cfg_dm1), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_data_i(tbl_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_cmd_i(in_cmd), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .full_o(full), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic [7:0] dm1);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m; cfg_dm1 = dm1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input logic c, input bit has_out,
                      input logic [15:0] e, input string t);
    @(negedge clk); in_valid = 1'b1; in_data = d; in_cmd = c; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (has_out) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); #2;
      if (exp_q.size() == 0) break;
    end
    chk(exp_q.size() == 0, "R10 outputs all delivered", 16'(exp_q.size()), 16'd0);
  endtask

  // monitor: compare every transferred output with the scoreboard head
  initial begin
    forever begin
      @(negedge clk); #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected output", out_data, 16'h0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(out_data === e, t, out_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 16'(out_valid), 16'd0);
    chk(full == 1'b0 && empty == 1'b0, "R1 flags after reset", {14'd0, full, empty}, 16'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 16'(in_ready), 16'd1);

    // R1 default delay of one
    send(16'h0011, 1'b0, 1'b1, 16'h0000, "R1 default delay first");
    send(16'h0022, 1'b0, 1'b1, 16'h0011, "R1 default delay second");
    drain();

    // R3 delay 3
    cfg(2'd0, 8'd2);
    for (int i = 0; i < 10; i++)
      send(16'(100 + i), 1'b0, 1'b1, (i < 3) ? 16'h0 : 16'(100 + i - 3), "R3 delay 3");
    drain();

    // R2 reconfiguration restarts the line empty
    cfg(2'd0, 8'd0);
    #1 chk(out_valid == 1'b0, "R2 out_valid cleared by config", 16'(out_valid), 16'd0);
    send(16'h0077, 1'b0, 1'b1, 16'h0000, "R2 delay restarts at zero");
    send(16'h0088, 1'b0, 1'b1, 16'h0077, "R3 delay 1");
    drain();

    // R3 delay 256
    cfg(2'd0, 8'd255);
    for (int i = 0; i < 260; i++)
      send(16'h5000 + 16'(i), 1'b0, 1'b1, (i < 256) ? 16'h0 : 16'h5000 + 16'(i - 256), "R3 delay 256");
    drain();

    // R7 table preload, R6 lookup with upper bits ignored
    for (int a = 0; a < 16; a++) preload(8'(a * 16 + 3), 16'(a * 257) ^ 16'hA5A5);
    cfg(2'd2, 8'd0);
    for (int a = 15; a >= 0; a--)
      send({8'(8'hF0 ^ a), 8'(a * 16 + 3)}, 1'b0, 1'b1, 16'(a * 257) ^ 16'hA5A5, "R6 R7 lookup");
    drain();

    // R10 back-pressure hold
    out_ready = 1'b0;
    send(16'h0013, 1'b0, 1'b1, 16'(1 * 257) ^ 16'hA5A5, "R10 held lookup delivered");
    held = 16'(1 * 257) ^ 16'hA5A5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b1 && out_data == held, "R10 output held", out_data, held);
      chk(in_ready == 1'b0, "R10 in_ready low while pending", 16'(in_ready), 16'd0);
    end
    @(negedge clk); out_ready = 1'b1;
    drain();

    // R8 RAM write, R9 RAM read
    cfg(2'd3, 8'd0);
    send(16'h0005, 1'b1, 1'b0, 16'h0, "");
    send(16'h1234, 1'b0, 1'b0, 16'h0, "");
    send(16'h00C8, 1'b1, 1'b0, 16'h0, "");
    send(16'hBEEF, 1'b0, 1'b0, 16'h0, "");
    send(16'h0007, 1'b1, 1'b0, 16'h0, "");
    send(16'h0042, 1'b1, 1'b0, 16'h0, "");
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R8 write words produce no output", 16'(out_valid), 16'd0);
    send(16'h0005, 1'b0, 1'b1, 16'h1234, "R9 read addr 5");
    send(16'h00C8, 1'b0, 1'b1, 16'hBEEF, "R9 read addr 200");
    send(16'h0007, 1'b0, 1'b1, 16'h0042, "R8 data word cmd ignored");
    send(16'h0003, 1'b0, 1'b1, 16'hA5A5, "R2 storage kept across modes");
    drain();

    // R4 R5 FIFO
    cfg(2'd1, 8'd0);
    #1;
    chk(empty == 1'b1 && full == 1'b0, "R4 fifo empty at start", {14'd0, full, empty}, 16'd1);
    chk(out_valid == 1'b0, "R5 no valid when empty", 16'(out_valid), 16'd0);
    out_ready = 1'b0;
    for (int i = 0; i < 256; i++)
      send(16'(i * 3 + 1), 1'b0, 1'b1, 16'(i * 3 + 1), "R4 fifo order");
    @(negedge clk); #1;
    chk(full == 1'b1 && empty == 1'b0, "R4 fifo full flag", {14'd0, full, empty}, 16'd2);
    chk(in_ready == 1'b0, "R5 in_ready low when full", 16'(in_ready), 16'd0);
    @(negedge clk); in_valid = 1'b1; in_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    drain();
    @(negedge clk); #1;
    chk(empty == 1'b1 && out_valid == 1'b0, "R5 refused word absent, empty again",
        {14'd0, out_valid, empty}, 16'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule